// File: doc/BRIEF.md
# Reset and Interrupt Priority Resolver

This block decides which of several simultaneous reset causes and interrupt requests the CPU services next. A fixed tier sits on top. It holds three reset causes, then a non-maskable interrupt line, then an exception slot that takes either an illegal-instruction trap or a software trap. Below it sits a tier of fifteen maskable sources. The CPU interrupt mask bit gates this tier as a whole. The maskable tier has a default order. A 5-bit select register can lift any one maskable source to the head of that tier, and the other sources keep their relative order.

Every source has a fixed 5-bit ID. Reset causes use 0 to 2: external pin or power-on is 0, clock-monitor is 1 and watchdog is 2. The non-maskable line is 3, the illegal-instruction trap is 4 and the software trap is 5. Maskable source k (bit k of `irq_req_i`) has ID 6+k. The bits in default order are: 0 external IRQ, 1 periodic tick, 2 to 4 capture 1 to 3, 5 to 9 compare 1 to 5, 10 timer overflow, 11 accumulator overflow, 12 accumulator edge, 13 SPI and 14 SCI. The select register holds the ID of the source to promote. The arbiter is combinational. The result is registered once per clock. Vector fetch and stacking are left to the CPU.

Top module: `irq_pri_top`

## Requirements
- R1: Reset causes rank ID 0 over ID 1 over ID 2, and any reset cause beats every other source.
- R2: The non-maskable line (ID 3) wins over everything except reset causes, and the mask bit does not block it.
- R3: The illegal-instruction trap (ID 4) and the software trap (ID 5) ignore the mask bit. They rank below ID 3 and above all maskable sources.
- R4: While `i_mask_i` is 1, no maskable source wins. If only maskable requests are pending, `valid_o` is 0.
- R5: With default ordering, a lower maskable bit index wins over a higher one, and the winner's ID is 6 plus its bit index.
- R6: Reset loads the select register with 5'b00110, which puts the external IRQ (ID 6) at the head of the maskable tier.
- R7: When the select register holds a maskable ID (6 to 20), that source wins over every other pending maskable source. The remaining maskable sources keep their default order.
- R8: A select value outside 6 to 20 leaves the default maskable order unchanged.
- R9: `is_reset_o` is 1 exactly when `valid_o` is 1 and the winner is a reset cause (ID 0 to 2).
- R10: Outputs are registered. They reflect the requests sampled at the previous rising clock edge. `valid_o` is 1 whenever some unmasked request was pending. During reset, `valid_o`, `src_id_o` and `is_reset_o` are all 0.
- R11: When `psel_we_i` is 1 at a rising edge, the select register takes `psel_d_i`. Arbitration uses the new value from that edge on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| rst_req_i | input | 3 | Reset causes: bit0 pin/power-on, bit1 clock monitor, bit2 watchdog |
| nmi_i | input | 1 | Non-maskable interrupt request |
| illop_i | input | 1 | Illegal-instruction trap request |
| swi_i | input | 1 | Software trap request |
| irq_req_i | input | 15 | Maskable requests, bit k has ID 6+k |
| i_mask_i | input | 1 | CPU interrupt mask bit |
| psel_we_i | input | 1 | Select register write strobe |
| psel_d_i | input | 5 | Select register write data |
| valid_o | output | 1 | A request won arbitration |
| src_id_o | output | 5 | ID of the winner |
| is_reset_o | output | 1 | Winner is a reset cause |

## Verification
A vector table drives layered patterns. All sources at once shows that the tiers nest correctly. Pairs of adjacent sources separate neighbouring ranks. A full maskable set with the mask bit high separates masked sources from unmasked ones. Directed cases then promote a middle source, the last source and a non-maskable ID. Each is checked against a mix of requests, which shows whether only the promoted source moved. A reset after a select write shows that the register returns to its reset value rather than keeping the last value written.

// File: rtl/irq_pri_pkg.sv
package irq_pri_pkg;
  localparam int unsigned N_RST   = 3;
  localparam int unsigned N_FIX   = N_RST + 3;   // resets, nmi, illop, swi
  localparam int unsigned N_MASK  = 15;
  localparam int unsigned ID_W    = 5;
  localparam int unsigned M_BASE  = N_FIX;       // first maskable ID
  localparam logic [ID_W-1:0] PSEL_RST = 5'b00110;
endpackage

// File: rtl/irq_psel_reg.sv
module irq_psel_reg #(
  parameter int unsigned W = 5,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         we_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= RST_VAL;
    else if (we_i) q_o <= d_i;
  end

  AST_PSEL_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(we_i) |-> q_o == $past(d_i)); // R11
endmodule

// File: rtl/irq_fixed_arb.sv
module irq_fixed_arb #(
  parameter int unsigned N_RST = 3,
  parameter int unsigned W     = 5
) (
  input  logic [N_RST-1:0] rst_req_i,
  input  logic             nmi_i,
  input  logic             illop_i,
  input  logic             swi_i,
  output logic             found_o,
  output logic [W-1:0]     id_o,
  output logic             is_rst_o
);
  localparam int unsigned N = N_RST + 3;
  logic [N-1:0] src;

  assign src      = {swi_i, illop_i, nmi_i, rst_req_i};
  assign is_rst_o = |rst_req_i;

  // lowest index wins
  always_comb begin
    found_o = 1'b0;
    id_o    = '0;
    for (int k = N - 1; k >= 0; k--) begin
      if (src[k]) begin
        found_o = 1'b1;
        id_o    = W'(k);
      end
    end
  end
endmodule

// File: rtl/irq_mask_arb.sv
module irq_mask_arb #(
  parameter int unsigned N    = 15,
  parameter int unsigned W    = 5,
  parameter int unsigned BASE = 6
) (
  input  logic [N-1:0] req_i,
  input  logic         mask_i,
  input  logic [W-1:0] psel_i,
  output logic         found_o,
  output logic [W-1:0] idx_o
);
  logic [N-1:0] eff;
  logic [N-1:0] hit;
  logic [N-1:0] promo;

  assign eff = mask_i ? '0 : req_i;

  // one-hot decode of the promoted source; out-of-range codes decode to zero
  for (genvar k = 0; k < N; k++) begin : g_sel
    assign hit[k]   = (psel_i == W'(BASE + k));
    assign promo[k] = hit[k] & eff[k];
  end

  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    for (int k = N - 1; k >= 0; k--) begin
      if (eff[k]) begin
        found_o = 1'b1;
        idx_o   = W'(k);
      end
    end
    for (int k = 0; k < N; k++) begin
      if (promo[k]) idx_o = W'(k);
    end
  end
endmodule

// File: rtl/irq_pri_top.sv
module irq_pri_top
  import irq_pri_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_RST-1:0]  rst_req_i,
  input  logic              nmi_i,
  input  logic              illop_i,
  input  logic              swi_i,
  input  logic [N_MASK-1:0] irq_req_i,
  input  logic              i_mask_i,
  input  logic              psel_we_i,
  input  logic [ID_W-1:0]   psel_d_i,
  output logic              valid_o,
  output logic [ID_W-1:0]   src_id_o,
  output logic              is_reset_o
);
  logic [ID_W-1:0] psel_q;
  logic            fix_found, fix_rst, msk_found;
  logic [ID_W-1:0] fix_id, msk_idx;
  logic            valid_d;
  logic [ID_W-1:0] id_d;

  irq_psel_reg #(.W(ID_W), .RST_VAL(PSEL_RST)) u_psel (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .we_i  (psel_we_i),
    .d_i   (psel_d_i),
    .q_o   (psel_q)
  );

  irq_fixed_arb #(.N_RST(N_RST), .W(ID_W)) u_fix (
    .rst_req_i(rst_req_i),
    .nmi_i    (nmi_i),
    .illop_i  (illop_i),
    .swi_i    (swi_i),
    .found_o  (fix_found),
    .id_o     (fix_id),
    .is_rst_o (fix_rst)
  );

  irq_mask_arb #(.N(N_MASK), .W(ID_W), .BASE(M_BASE)) u_msk (
    .req_i  (irq_req_i),
    .mask_i (i_mask_i),
    .psel_i (psel_q),
    .found_o(msk_found),
    .idx_o  (msk_idx)
  );

  always_comb begin
    valid_d = fix_found | msk_found;
    if (fix_found)      id_d = fix_id;
    else if (msk_found) id_d = msk_idx + ID_W'(M_BASE);
    else                id_d = '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o    <= 1'b0;
      src_id_o   <= '0;
      is_reset_o <= 1'b0;
    end else begin
      valid_o    <= valid_d;
      src_id_o   <= id_d;
      is_reset_o <= fix_rst;
    end
  end

  AST_POR_FIRST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rst_req_i[0]) |-> valid_o && src_id_o == '0); // R1
  AST_NMI_RANK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(nmi_i && rst_req_i == '0) |-> valid_o && src_id_o == ID_W'(N_RST)); // R2
  AST_MASK_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(i_mask_i) |-> !(valid_o && src_id_o >= ID_W'(M_BASE))); // R4
  AST_RST_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_reset_o == (valid_o && src_id_o < ID_W'(N_RST))); // R9
  AST_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(|rst_req_i || nmi_i || illop_i || swi_i) |-> valid_o); // R10
endmodule

// File: tb/irq_pri_top_tb_top.sv
module irq_pri_top_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 15;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [2:0]  rst_req = '0;
  logic        nmi = 1'b0, illop = 1'b0, swi = 1'b0, imask = 1'b0;
  logic [14:0] req = '0;
  logic        psel_we = 1'b0;
  logic [4:0]  psel_d = '0;
  logic        valid, is_rst;
  logic [4:0]  id;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_pri_top dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .rst_req_i(rst_req), .nmi_i(nmi),
    .illop_i(illop), .swi_i(swi), .irq_req_i(req), .i_mask_i(imask),
    .psel_we_i(psel_we), .psel_d_i(psel_d),
    .valid_o(valid), .src_id_o(id), .is_reset_o(is_rst)
  );

  // {rst[2:0], nmi, illop, swi, mask, req[14:0], exp_valid, exp_id[4:0]}
  localparam logic [27:0] VEC [NV] = '{
    {3'b000, 1'b0, 1'b0, 1'b0, 1'b0, 15'h0000, 1'b0, 5'd0},  // idle R10
    {3'b111, 1'b1, 1'b1, 1'b0, 1'b0, 15'h7FFF, 1'b1, 5'd0},  // R1
    {3'b110, 1'b1, 1'b0, 1'b0, 1'b0, 15'h7FFF, 1'b1, 5'd1},  // R1
    {3'b100, 1'b1, 1'b0, 1'b1, 1'b0, 15'h7FFF, 1'b1, 5'd2},  // R1
    {3'b000, 1'b1, 1'b1, 1'b0, 1'b0, 15'h7FFF, 1'b1, 5'd3},  // R2
    {3'b000, 1'b1, 1'b0, 1'b0, 1'b1, 15'h0001, 1'b1, 5'd3},  // R2 masked
    {3'b000, 1'b0, 1'b1, 1'b0, 1'b0, 15'h7FFF, 1'b1, 5'd4},  // R3
    {3'b000, 1'b0, 1'b0, 1'b1, 1'b1, 15'h7FFF, 1'b1, 5'd5},  // R3 masked
    {3'b000, 1'b0, 1'b0, 1'b0, 1'b0, 15'h7FFF, 1'b1, 5'd6},  // R5
    {3'b000, 1'b0, 1'b0, 1'b0, 1'b1, 15'h7FFF, 1'b0, 5'd0},  // R4
    {3'b000, 1'b0, 1'b0, 1'b0, 1'b0, 15'h0002, 1'b1, 5'd7},  // R5
    {3'b000, 1'b0, 1'b0, 1'b0, 1'b0, 15'h0006, 1'b1, 5'd7},  // R5
    {3'b000, 1'b0, 1'b0, 1'b0, 1'b0, 15'h4000, 1'b1, 5'd20}, // R5
    {3'b000, 1'b0, 1'b0, 1'b0, 1'b0, 15'h6000, 1'b1, 5'd19}, // R5
    {3'b000, 1'b0, 1'b0, 1'b0, 1'b0, 15'h0300, 1'b1, 5'd14}  // R5
  };

  task automatic check(input bit ev, input logic [4:0] eid, input string tag);
    bit er;
    er = ev && (eid < 5'd3);
    checks++;
    if (valid !== ev || (ev && id !== eid) || is_rst !== er) begin
      fails++;
      $display("FAIL %s: valid=%0b id=%0d is_reset=%0b expected valid=%0b id=%0d is_reset=%0b",
               tag, valid, id, is_rst, ev, eid, er);
    end
  endtask

  task automatic apply(input logic [27:0] v);
    @(negedge clk);
    rst_req = v[27:25]; nmi = v[24]; illop = v[23]; swi = v[22];
    imask = v[21]; req = v[20:6];
    @(negedge clk);
    check(v[5], v[4:0], "R10 vector");
  endtask

  task automatic reqs(input logic m, input logic [14:0] r, input bit ev,
                      input logic [4:0] eid, input string tag);
    @(negedge clk);
    rst_req = '0; nmi = 1'b0; illop = 1'b0; swi = 1'b0; imask = m; req = r;
    @(negedge clk);
    check(ev, eid, tag);
  endtask

  task automatic set_psel(input logic [4:0] p);
    @(negedge clk);
    psel_we = 1'b1; psel_d = p;
    @(negedge clk);
    psel_we = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(1'b0, 5'd0, "R10 reset state");
    rst_ni = 1'b1;

    for (int i = 0; i < NV; i++) apply(VEC[i]);

    // level input held: stays pending
    reqs(1'b0, 15'h0001, 1'b1, 5'd6, "R5 held irq");
    reqs(1'b0, 15'h0000, 1'b0, 5'd0, "R10 release");

    // promotion of capture 1 (ID 8)
    set_psel(5'd8);
    reqs(1'b0, 15'h0007, 1'b1, 5'd8, "R7 promote mid");
    reqs(1'b0, 15'h0003, 1'b1, 5'd6, "R7 rest order");
    reqs(1'b0, 15'h0006, 1'b1, 5'd8, "R7 over rti");
    reqs(1'b1, 15'h0004, 1'b0, 5'd0, "R4 promoted masked");
    @(negedge clk); nmi = 1'b1; req = 15'h0004; imask = 1'b0;
    @(negedge clk); check(1'b1, 5'd3, "R2 over promoted");

    // promotion of the last source
    set_psel(5'd20);
    reqs(1'b0, 15'h7FFF, 1'b1, 5'd20, "R7 promote last");
    reqs(1'b0, 15'h3FFE, 1'b1, 5'd7, "R7 rest order last");

    // R11: write and request in same window; new code used after edge
    @(negedge clk);
    psel_we = 1'b1; psel_d = 5'd9; req = 15'h0009; imask = 1'b0; nmi = 1'b0;
    @(negedge clk);
    psel_we = 1'b0;
    check(1'b1, 5'd6, "R11 old select before edge");
    @(negedge clk);
    check(1'b1, 5'd9, "R11 new select");

    // codes naming no maskable source
    set_psel(5'd31);
    reqs(1'b0, 15'h0006, 1'b1, 5'd7, "R8 code 31");
    set_psel(5'd3);
    reqs(1'b0, 15'h0003, 1'b1, 5'd6, "R8 code 3");
    set_psel(5'd21);
    reqs(1'b0, 15'h4002, 1'b1, 5'd7, "R8 code 21");

    // reset value of select register
    set_psel(5'd20);
    reqs(1'b0, 15'h4001, 1'b1, 5'd20, "R6 before reset");
    @(negedge clk); rst_ni = 1'b0;
    @(negedge clk);
    check(1'b0, 5'd0, "R10 reset mid-run");
    rst_ni = 1'b1;
    reqs(1'b0, 15'h4001, 1'b1, 5'd6, "R6 after reset");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule